// File: doc/BRIEF.md
# Outstanding Miss and Invalidation Tracker

This block sits at one site of a distributed shared-memory machine whose network may reorder messages. It keeps a small associative table of remote reads that are still waiting for their cache line. Every coherence message that reaches the site passes through it. There are three kinds of message: an invalidation, a data reply, and a reply telling the requester to read again. For each message the block picks one action: drive a local bus invalidate, acknowledge the invalidation with no bus action, park the invalidation in the table entry, or complete the pending read.

The point of the block is that an invalidation which races with an outstanding read is never blocked indefinitely. The action depends on which message of the race arrives second. A parked invalidation is resolved by whatever reply follows it. A read-again reply may also arrive before its invalidation. In that case the entry remembers it and asks for the read to be sent again once the invalidation has been handled.

Top module: `miss_inval_tracker`

## Requirements
- R1: After reset no output pulse or bus invalidate is active, and both `req_ready` and `msg_ready` are 1.
- R2: An invalidation (`msg_kind` 0) for an address with no tracked read raises `bus_inv_valid` with that address in the next cycle. The request is held with a stable address until `bus_inv_ready`. The cycle after that handshake carries a one-cycle `ack_valid` with the same address.
- R3: An invalidation for a tracked address whose entry has no read-again mark is parked in the entry. It causes no bus invalidate and no acknowledgement.
- R4: A data reply (`msg_kind` 1) for an entry holding a parked invalidation delivers the data. In the same cycle the bus invalidate for that address is raised. The entry stays occupied until the bus handshake and is freed at that handshake.
- R5: A read-again reply (`msg_kind` 2) for an entry holding a parked invalidation gives, in the next cycle, an acknowledgement and a re-issue pulse for that address, with no bus invalidate. The read stays tracked.
- R6: A read-again reply for an entry with no parked invalidation produces no output and marks the entry. A later invalidation for it then gives an acknowledgement and a re-issue pulse, with no bus invalidate.
- R7: A data reply for an entry with no parked invalidation gives a one-cycle `dlv_valid` with its address and data in the next cycle. It frees the entry at once.
- R8: A request for an address already tracked is merged: it is accepted even with the table full and takes no new entry.
- R9: With all entries occupied, judged on the table as it stood before the edge, a request for a new address is refused with `req_ready` 0.
- R10: Data and read-again replies for an untracked address produce no output.
- R11: While a bus invalidate is pending, `msg_ready` is 0.
- R12: A request whose address equals that of a message accepted in the same cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A new remote read is being recorded |
| req_addr | input | AW | Line address of the read |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| msg_valid | input | 1 | Incoming coherence message present |
| msg_kind | input | 2 | 0 invalidate, 1 data, 2 read again |
| msg_addr | input | AW | Line address of the message |
| msg_data | input | DW | Line data carried by a data reply |
| msg_ready | output | 1 | Message accepted this cycle when high with msg_valid |
| bus_inv_valid | output | 1 | Local bus invalidate request |
| bus_inv_addr | output | AW | Address to invalidate |
| bus_inv_ready | input | 1 | Bus has taken the invalidate |
| ack_valid | output | 1 | One-cycle invalidation acknowledgement |
| ack_addr | output | AW | Address acknowledged |
| dlv_valid | output | 1 | One-cycle data delivery |
| dlv_addr | output | AW | Address delivered |
| dlv_data | output | DW | Data delivered |
| reiss_valid | output | 1 | One-cycle request to send the read again |
| reiss_addr | output | AW | Address to read again |

## Verification
Two pairs of functions can fall in the same cycle: a request with a message, and a data delivery with a bus invalidate. The first pair is provoked on a full table. A request for a new address is presented in the same cycle as a data reply that frees an entry, and it must still be refused. A request that matches the address of the message in flight must also be refused. The second pair is provoked by a data reply for an entry with a parked invalidation. It is judged by seeing delivery and bus request appear together, with the acknowledgement only after the handshake and the entry still occupied until then.

// File: rtl/mit_pkg.sv
package mit_pkg;
  typedef enum logic [1:0] {
    MK_INVAL = 2'd0,
    MK_DATA  = 2'd1,
    MK_RETRY = 2'd2
  } msg_kind_e;

  typedef struct packed {
    logic live;   // slot holds an outstanding read
    logic drain;  // data delivered, bus invalidate still owed
    logic retry;  // read-again seen before its invalidation
    logic held;   // invalidation parked in the slot
  } slot_flags_t;
endpackage

// File: rtl/mit_match.sv
module mit_match #(
  parameter int N  = 8,
  parameter int AW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [AW-1:0]       key,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0]        elig,
  output logic [N-1:0]        hit_vec,
  output logic                hit,
  output logic [IW-1:0]       hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = elig[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/mit_pick.sv
module mit_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IW'(i);
    end
  end

  assign any_free = |free_vec;
endmodule

// File: rtl/miss_inval_tracker.sv
module miss_inval_tracker
  import mit_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 8,
  parameter int DW      = 16,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  input  logic          msg_valid,
  input  logic [1:0]    msg_kind,
  input  logic [AW-1:0] msg_addr,
  input  logic [DW-1:0] msg_data,
  output logic          msg_ready,
  output logic          bus_inv_valid,
  output logic [AW-1:0] bus_inv_addr,
  input  logic          bus_inv_ready,
  output logic          ack_valid,
  output logic [AW-1:0] ack_addr,
  output logic          dlv_valid,
  output logic [AW-1:0] dlv_addr,
  output logic [DW-1:0] dlv_data,
  output logic          reiss_valid,
  output logic [AW-1:0] reiss_addr
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // table state
  slot_flags_t [ENTRIES-1:0]         flags_q, flags_d;
  logic        [ENTRIES-1:0][AW-1:0] tags_q, tags_d;
  logic        [IW-1:0]              drain_idx_q, drain_idx_d;
  logic                              drain_live_q, drain_live_d;

  // registered outputs
  logic          binv_q, binv_d;
  logic [AW-1:0] binv_addr_q, binv_addr_d;
  logic          ack_q, ack_d;
  logic [AW-1:0] ack_addr_q, ack_addr_d;
  logic          dlv_q, dlv_d;
  logic [AW-1:0] dlv_addr_q, dlv_addr_d;
  logic [DW-1:0] dlv_data_q, dlv_data_d;
  logic          reiss_q, reiss_d;
  logic [AW-1:0] reiss_addr_q, reiss_addr_d;

  // lookups
  logic [ENTRIES-1:0] elig, free_vec, req_hits, msg_hits;
  logic               req_hit, msg_hit, any_free;
  logic [IW-1:0]      req_idx, msg_idx, free_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      elig[i]     = flags_q[i].live && !flags_q[i].drain;
      free_vec[i] = !flags_q[i].live;
    end
  end

  mit_match #(.N(ENTRIES), .AW(AW)) i_req_match (
    .key(req_addr), .tags(tags_q), .elig(elig),
    .hit_vec(req_hits), .hit(req_hit), .hit_idx(req_idx)
  );

  mit_match #(.N(ENTRIES), .AW(AW)) i_msg_match (
    .key(msg_addr), .tags(tags_q), .elig(elig),
    .hit_vec(msg_hits), .hit(msg_hit), .hit_idx(msg_idx)
  );

  mit_pick #(.N(ENTRIES)) i_pick (
    .free_vec(free_vec), .any_free(any_free), .free_idx(free_idx)
  );

  // handshakes
  logic msg_fire, req_fire, bus_fire, same_line;
  assign msg_ready = rst_sync_n && !binv_q;
  assign msg_fire  = msg_valid && msg_ready;
  assign same_line = msg_fire && (msg_addr == req_addr);
  assign req_ready = rst_sync_n && (req_hit || any_free) && !same_line;
  assign req_fire  = req_valid && req_ready;
  assign bus_fire  = binv_q && bus_inv_ready;

  // next state
  always_comb begin
    flags_d      = flags_q;
    tags_d       = tags_q;
    drain_idx_d  = drain_idx_q;
    drain_live_d = drain_live_q;
    binv_d       = binv_q;
    binv_addr_d  = binv_addr_q;
    ack_d        = 1'b0;
    ack_addr_d   = ack_addr_q;
    dlv_d        = 1'b0;
    dlv_addr_d   = dlv_addr_q;
    dlv_data_d   = dlv_data_q;
    reiss_d      = 1'b0;
    reiss_addr_d = reiss_addr_q;

    // bus took the invalidate: acknowledge it and release a draining slot
    if (bus_fire) begin
      binv_d     = 1'b0;
      ack_d      = 1'b1;
      ack_addr_d = binv_addr_q;
      if (drain_live_q) begin
        flags_d[drain_idx_q] = '0;
        drain_live_d         = 1'b0;
      end
    end

    if (msg_fire) begin
      unique case (msg_kind_e'(msg_kind))
        MK_INVAL: begin
          if (!msg_hit) begin
            binv_d       = 1'b1;
            binv_addr_d  = msg_addr;
            drain_live_d = 1'b0;
          end else if (flags_q[msg_idx].retry) begin
            flags_d[msg_idx].retry = 1'b0;
            ack_d        = 1'b1;
            ack_addr_d   = msg_addr;
            reiss_d      = 1'b1;
            reiss_addr_d = msg_addr;
          end else begin
            flags_d[msg_idx].held = 1'b1;
          end
        end
        MK_DATA: begin
          if (msg_hit) begin
            dlv_d      = 1'b1;
            dlv_addr_d = msg_addr;
            dlv_data_d = msg_data;
            if (flags_q[msg_idx].held) begin
              flags_d[msg_idx].drain = 1'b1;
              flags_d[msg_idx].held  = 1'b0;
              binv_d       = 1'b1;
              binv_addr_d  = msg_addr;
              drain_idx_d  = msg_idx;
              drain_live_d = 1'b1;
            end else begin
              flags_d[msg_idx] = '0;
            end
          end
        end
        MK_RETRY: begin
          if (msg_hit) begin
            if (flags_q[msg_idx].held) begin
              flags_d[msg_idx].held = 1'b0;
              ack_d        = 1'b1;
              ack_addr_d   = msg_addr;
              reiss_d      = 1'b1;
              reiss_addr_d = msg_addr;
            end else begin
              flags_d[msg_idx].retry = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

    // allocation for a new line; merged requests leave the table alone
    if (req_fire && !req_hit) begin
      flags_d[free_idx]      = '0;
      flags_d[free_idx].live = 1'b1;
      tags_d[free_idx]       = req_addr;
    end
  end

  // registers
  logic tbl_en, out_en;
  assign tbl_en = msg_fire || req_fire || bus_fire;
  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q      <= '0;
      tags_q       <= '0;
      drain_idx_q  <= '0;
      drain_live_q <= 1'b0;
    end else if (tbl_en) begin
      flags_q      <= flags_d;
      tags_q       <= tags_d;
      drain_idx_q  <= drain_idx_d;
      drain_live_q <= drain_live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      binv_q       <= 1'b0;
      binv_addr_q  <= '0;
      ack_q        <= 1'b0;
      ack_addr_q   <= '0;
      dlv_q        <= 1'b0;
      dlv_addr_q   <= '0;
      dlv_data_q   <= '0;
      reiss_q      <= 1'b0;
      reiss_addr_q <= '0;
    end else if (out_en) begin
      binv_q       <= binv_d;
      binv_addr_q  <= binv_addr_d;
      ack_q        <= ack_d;
      ack_addr_q   <= ack_addr_d;
      dlv_q        <= dlv_d;
      dlv_addr_q   <= dlv_addr_d;
      dlv_data_q   <= dlv_data_d;
      reiss_q      <= reiss_d;
      reiss_addr_q <= reiss_addr_d;
    end
  end

  assign bus_inv_valid = binv_q;
  assign bus_inv_addr  = binv_addr_q;
  assign ack_valid     = ack_q;
  assign ack_addr      = ack_addr_q;
  assign dlv_valid     = dlv_q;
  assign dlv_addr      = dlv_addr_q;
  assign dlv_data      = dlv_data_q;
  assign reiss_valid   = reiss_q;
  assign reiss_addr    = reiss_addr_q;

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_inv_valid && !bus_inv_ready) |=> (bus_inv_valid && $stable(bus_inv_addr)));

  // R11
  msg_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_inv_valid |-> !msg_ready);

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_valid |-> $past(bus_fire || msg_fire));

  // R5
  reiss_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reiss_valid |-> (ack_valid && ack_addr == reiss_addr && !$rose(bus_inv_valid)));

  // R8
  single_tag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(req_hits) && $onehot0(msg_hits));

  // R4
  drain_order_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(bus_inv_valid) && drain_live_q) |-> (dlv_valid && dlv_addr == bus_inv_addr));
endmodule

// File: tb/test_miss_inval_tracker.sv
module test_miss_inval_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic          msg_valid;
  logic [1:0]    msg_kind;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;
  logic          msg_ready;
  logic          bus_inv_valid;
  logic [AW-1:0] bus_inv_addr;
  logic          bus_inv_ready;
  logic          ack_valid;
  logic [AW-1:0] ack_addr;
  logic          dlv_valid;
  logic [AW-1:0] dlv_addr;
  logic [DW-1:0] dlv_data;
  logic          reiss_valid;
  logic [AW-1:0] reiss_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  miss_inval_tracker #(.ENTRIES(8), .AW(AW), .DW(DW)) i_miss_inval_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_ready(msg_ready),
    .bus_inv_valid(bus_inv_valid), .bus_inv_addr(bus_inv_addr),
    .bus_inv_ready(bus_inv_ready),
    .ack_valid(ack_valid), .ack_addr(ack_addr),
    .dlv_valid(dlv_valid), .dlv_addr(dlv_addr), .dlv_data(dlv_data),
    .reiss_valid(reiss_valid), .reiss_addr(reiss_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outputs that must all be quiet
  task automatic chk_quiet(input string tag);
    chk({tag, " bus"},   32'(bus_inv_valid), 0);
    chk({tag, " ack"},   32'(ack_valid),     0);
    chk({tag, " dlv"},   32'(dlv_valid),     0);
    chk({tag, " reiss"}, 32'(reiss_valid),   0);
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic exp_ready, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1 chk({tag, " req_ready"}, 32'(req_ready), 32'(exp_ready));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // returns one step after the accepting edge, registered outputs visible
  task automatic do_msg(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    msg_valid = 1'b1;
    msg_kind  = k;
    msg_addr  = a;
    msg_data  = d;
    @(posedge clk);
    #1 msg_valid = 1'b0;
  endtask

  task automatic bus_take(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    bus_inv_ready = 1'b1;
    @(posedge clk);
    #1 bus_inv_ready = 1'b0;
    chk({tag, " ack after handshake"}, 32'(ack_valid), 1);
    chk({tag, " ack addr"}, 32'(ack_addr), 32'(a));
    chk({tag, " bus dropped"}, 32'(bus_inv_valid), 0);
  endtask

  task automatic t_reset();
    chk_quiet("R1 reset");
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 msg_ready", 32'(msg_ready), 1);
  endtask

  task automatic t_plain_inval();
    do_msg(2'd0, 8'h40, '0);
    chk("R2 bus raised", 32'(bus_inv_valid), 1);
    chk("R2 bus addr", 32'(bus_inv_addr), 32'h40);
    chk("R2 no early ack", 32'(ack_valid), 0);
    chk("R11 msg stalled", 32'(msg_ready), 0);
    @(posedge clk);
    #1 chk("R2 bus held", 32'(bus_inv_valid), 1);
    chk("R2 addr held", 32'(bus_inv_addr), 32'h40);
    bus_take(8'h40, "R2");
    chk("R11 msg resumes", 32'(msg_ready), 1);
    @(posedge clk);
    #1 chk("R2 ack one cycle", 32'(ack_valid), 0);
  endtask

  task automatic t_held_then_data();
    do_req(8'h10, 1'b1, "R3");
    do_msg(2'd0, 8'h10, '0);
    chk_quiet("R3 parked");
    do_msg(2'd1, 8'h10, 16'hABCD);
    chk("R4 delivered", 32'(dlv_valid), 1);
    chk("R4 dlv addr", 32'(dlv_addr), 32'h10);
    chk("R4 dlv data", 32'(dlv_data), 32'hABCD);
    chk("R4 bus with delivery", 32'(bus_inv_valid), 1);
    chk("R4 bus addr", 32'(bus_inv_addr), 32'h10);
    chk("R4 no ack yet", 32'(ack_valid), 0);
    bus_take(8'h10, "R4");
    // slot freed: the next invalidation goes to the bus
    do_msg(2'd0, 8'h10, '0);
    chk("R4 freed after handshake", 32'(bus_inv_valid), 1);
    bus_take(8'h10, "R4 free");
  endtask

  task automatic t_held_then_retry();
    do_req(8'h20, 1'b1, "R5");
    do_msg(2'd0, 8'h20, '0);
    do_msg(2'd2, 8'h20, '0);
    chk("R5 ack", 32'(ack_valid), 1);
    chk("R5 ack addr", 32'(ack_addr), 32'h20);
    chk("R5 reissue", 32'(reiss_valid), 1);
    chk("R5 reissue addr", 32'(reiss_addr), 32'h20);
    chk("R5 no bus", 32'(bus_inv_valid), 0);
    do_msg(2'd1, 8'h20, 16'h1234);
    chk("R5 still tracked", 32'(dlv_valid), 1);
    chk("R5 no bus after data", 32'(bus_inv_valid), 0);
  endtask

  task automatic t_retry_first();
    do_req(8'h30, 1'b1, "R6");
    do_msg(2'd2, 8'h30, '0);
    chk_quiet("R6 retry recorded");
    do_msg(2'd0, 8'h30, '0);
    chk("R6 ack", 32'(ack_valid), 1);
    chk("R6 reissue", 32'(reiss_valid), 1);
    chk("R6 reissue addr", 32'(reiss_addr), 32'h30);
    chk("R6 no bus", 32'(bus_inv_valid), 0);
    do_msg(2'd1, 8'h30, 16'h5A5A);
    chk("R7 delivered", 32'(dlv_valid), 1);
    chk("R7 dlv data", 32'(dlv_data), 32'h5A5A);
    chk("R7 no bus", 32'(bus_inv_valid), 0);
    @(posedge clk);
    #1 chk("R7 one-cycle pulse", 32'(dlv_valid), 0);
    do_msg(2'd0, 8'h30, '0);
    chk("R7 freed at once", 32'(bus_inv_valid), 1);
    bus_take(8'h30, "R7");
  endtask

  task automatic t_stray();
    do_msg(2'd1, 8'h55, 16'hFFFF);
    chk_quiet("R10 stray data");
    do_msg(2'd2, 8'h55, '0);
    chk_quiet("R10 stray retry");
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) do_req(8'h80 + 8'(i), 1'b1, "R9 fill");
    do_req(8'h90, 1'b0, "R9 full refuses");
    do_req(8'h83, 1'b1, "R8 merge when full");
    do_msg(2'd1, 8'h83, 16'h0083);
    chk("R8 merged line delivered", 32'(dlv_valid), 1);
    do_req(8'h90, 1'b1, "R8 one slot freed");
    do_req(8'h91, 1'b0, "R8 merge took no slot");
    // a draining slot stays occupied until the bus handshake
    do_msg(2'd0, 8'h84, '0);
    do_msg(2'd1, 8'h84, 16'h0084);
    chk("R4 drain bus", 32'(bus_inv_valid), 1);
    do_req(8'h91, 1'b0, "R4 draining slot occupied");
    bus_take(8'h84, "R4 drain");
    do_req(8'h91, 1'b1, "R4 slot released");
    // free and allocate in the same cycle: the refusal stands
    @(negedge clk);
    msg_valid = 1'b1; msg_kind = 2'd1; msg_addr = 8'h86; msg_data = 16'h0086;
    req_valid = 1'b1; req_addr = 8'hA0;
    #1 chk("R9 full judged before edge", 32'(req_ready), 0);
    // same line as the message: refused even though it would merge
    req_addr = 8'h86;
    #1 chk("R12 same-line refused", 32'(req_ready), 0);
    @(posedge clk);
    #1 msg_valid = 1'b0; req_valid = 1'b0;
    chk("R9 delivery same cycle", 32'(dlv_valid), 1);
    do_req(8'hA0, 1'b1, "R9 slot after free");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    msg_valid = 1'b0; msg_kind = '0; msg_addr = '0; msg_data = '0;
    bus_inv_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_plain_inval();
    t_held_then_data();
    t_held_then_retry();
    t_retry_first();
    t_stray();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule